// File: doc/BRIEF.md
# MESI Snooping Line Controller

This block keeps the four-state coherence state of every line of one write-back, write-invalidate cache that sits on a shared snooping bus. The local processor presents one request at a time: read, write or evict, together with a line index. The controller either completes the request locally or raises a bus request of the proper kind. It completes the request in the cycle the arbiter grants the bus. In parallel it watches transactions from other caches on the same bus. It answers with a flush indication when it must supply dirty data, and with a shared indication when it holds a valid copy. Data storage, tag comparison, arbitration and memory timing stay outside the block. Two lines are treated as the same address when their indices match.

The shared indication from the other caches is sampled in the grant cycle of this controller's own bus read. When no other cache has a copy, the line is filled in an exclusive-clean state. A later write to that line then needs no bus transaction at all.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. The state code on `cpu_state` is Invalid=0, Shared=1, Exclusive=2, Modified=3.
- R2: A read (`cpu_req_op`=0) to a line in Shared, Exclusive or Modified completes in the same cycle (`cpu_done`=1). It raises no bus request and leaves the state unchanged.
- R3: A read to an Invalid line raises `bus_req` with `bus_req_op`=1 (bus read; 2 is read-exclusive, 3 is write-back, 0 is none) and keeps `cpu_done` low until `bus_grant`. In the grant cycle the request completes, and the line becomes Shared if `bus_shared_in` is high or Exclusive if it is low.
- R4: A write (`cpu_req_op`=1) to an Exclusive line completes at once with no bus request and makes the line Modified. A write to a Modified line completes at once with no change.
- R5: A write to a Shared or Invalid line raises a read-exclusive bus request. On grant it completes and the line becomes Modified.
- R6: A snooped bus read (`snoop_op`=1) to a Modified line asserts `flush` in that cycle and leaves the line Shared. To an Exclusive line it gives Shared without a flush. Shared and Invalid lines are unchanged.
- R7: A snooped read-exclusive (`snoop_op`=2) to a Modified line asserts `flush` and leaves the line Invalid. To a Shared or Exclusive line it gives Invalid without a flush.
- R8: An evict (`cpu_req_op`=2) of a Modified line raises a write-back bus request, and on grant the line becomes Invalid. An evict of a Shared or Exclusive line completes at once and leaves it Invalid with no bus request. An evict of an Invalid line completes with no change.
- R9: `shared_out` is high during a snoop exactly when the snooped line is valid. A snooped write-back (`snoop_op`=3) changes no state and causes no flush.
- R10: A snoop on the line addressed by a local request that needs no bus holds `cpu_done` low for that cycle, and the snoop's transition is applied. A snoop changes only the line it names.
- R11: `bus_grant` with no pending bus request changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Local request present, held until `cpu_done` |
| cpu_req_op | input | 2 | 0 read, 1 write, 2 evict |
| cpu_req_line | input | IDX_W | Line index of the local request; also selects `cpu_state` |
| cpu_state | output | 2 | Current state of line `cpu_req_line` |
| cpu_done | output | 1 | Local request completes this cycle |
| bus_req | output | 1 | Controller needs a bus transaction |
| bus_req_op | output | 2 | Kind of transaction needed |
| bus_grant | input | 1 | Own transaction is on the bus this cycle |
| bus_shared_in | input | 1 | Another cache holds the line, valid in the grant cycle |
| snoop_valid | input | 1 | Another cache's transaction is on the bus |
| snoop_op | input | 2 | Snooped transaction kind (1 read, 2 read-exclusive, 3 write-back) |
| snoop_line | input | IDX_W | Line index of the snooped transaction |
| flush | output | 1 | This cache must supply the snooped line's data |
| shared_out | output | 1 | This cache holds the snooped line in a valid state |

## Verification
A corrupted line state shows up at the ports within one cycle of the next access to that line. A wrong state code appears on `cpu_state`, and a wrongly missed or raised bus request appears on `bus_req`. A missing or extra `flush` or `shared_out` appears during the next snoop of the line. So the sweep drives every line into each of the four states and applies every local and snooped event. It then reads the resulting state on the cycle after the transition, which makes any bad transition visible right away rather than several accesses later.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_EVICT = 2'd2,
    OP_RSVD  = 2'd3
  } cpu_op_t;

  typedef enum logic [1:0] {
    BUS_NONE = 2'd0,
    BUS_RD   = 2'd1,
    BUS_RDX  = 2'd2,
    BUS_WB   = 2'd3
  } bus_op_t;

endpackage

// File: rtl/mesi_cpu_side.sv
module mesi_cpu_side
  import mesi_pkg::*;
(
  input  logic     req_valid,
  input  cpu_op_t  req_op,
  input  line_st_t cur_st,
  input  logic     grant,
  input  logic     shared_in,
  input  logic     blocked,
  output logic     bus_req,
  output bus_op_t  bus_op,
  output logic     done,
  output line_st_t nxt_st
);

  bus_op_t need_op;

  always_comb begin
    need_op = BUS_NONE;
    nxt_st  = cur_st;
    unique case (req_op)
      OP_READ: begin
        if (cur_st == ST_I) begin
          need_op = BUS_RD;
          nxt_st  = shared_in ? ST_S : ST_E;
        end
      end
      OP_WRITE: begin
        if (cur_st == ST_I || cur_st == ST_S) need_op = BUS_RDX;
        nxt_st = ST_M;
      end
      OP_EVICT: begin
        if (cur_st == ST_M) need_op = BUS_WB;
        nxt_st = ST_I;
      end
      default: begin
        nxt_st = cur_st;
      end
    endcase
  end

  always_comb begin
    bus_req = req_valid && (need_op != BUS_NONE);
    bus_op  = bus_req ? need_op : BUS_NONE;
    if (!req_valid)                done = 1'b0;
    else if (need_op != BUS_NONE)  done = grant;
    else                           done = !blocked;
  end

endmodule

// File: rtl/mesi_snoop_side.sv
module mesi_snoop_side
  import mesi_pkg::*;
(
  input  logic     snp_valid,
  input  bus_op_t  snp_op,
  input  line_st_t cur_st,
  output logic     flush,
  output logic     shared_out,
  output logic     upd,
  output line_st_t nxt_st
);

  always_comb begin
    nxt_st = cur_st;
    flush  = 1'b0;
    unique case (snp_op)
      BUS_RD: begin
        if (cur_st == ST_M) flush = 1'b1;
        if (cur_st == ST_M || cur_st == ST_E) nxt_st = ST_S;
      end
      BUS_RDX: begin
        if (cur_st == ST_M) flush = 1'b1;
        nxt_st = ST_I;
      end
      default: begin
        nxt_st = cur_st;
      end
    endcase
    flush      = flush && snp_valid;
    shared_out = snp_valid && (cur_st != ST_I);
    upd        = snp_valid;
  end

endmodule

// File: rtl/mesi_state_store.sv
module mesi_state_store
  import mesi_pkg::*;
#(
  parameter int LINES = 8,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 snp_we,
  input  logic [IDX_W-1:0]     snp_idx,
  input  line_st_t             snp_st,
  input  logic                 cpu_we,
  input  logic [IDX_W-1:0]     cpu_idx,
  input  line_st_t             cpu_st,
  output line_st_t [LINES-1:0] st_q
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic     hit_snp;
    logic     hit_cpu;
    logic     en;
    line_st_t d;

    always_comb begin
      hit_snp = snp_we && (snp_idx == IDX_W'(g));
      hit_cpu = cpu_we && (cpu_idx == IDX_W'(g));
      en      = hit_snp || hit_cpu;
      d       = hit_snp ? snp_st : cpu_st;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  st_q[g] <= ST_I;
      else if (en) st_q[g] <= d;
    end
  end

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int LINES = 8,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req_valid,
  input  logic [1:0]       cpu_req_op,
  input  logic [IDX_W-1:0] cpu_req_line,
  output logic [1:0]       cpu_state,
  output logic             cpu_done,
  output logic             bus_req,
  output logic [1:0]       bus_req_op,
  input  logic             bus_grant,
  input  logic             bus_shared_in,
  input  logic             snoop_valid,
  input  logic [1:0]       snoop_op,
  input  logic [IDX_W-1:0] snoop_line,
  output logic             flush,
  output logic             shared_out
);

  line_st_t [LINES-1:0] st_q;
  line_st_t cpu_cur, snp_cur, cpu_nxt, snp_nxt;
  bus_op_t  req_op_w;
  logic     snp_upd, same_line;

  assign cpu_cur   = st_q[cpu_req_line];
  assign snp_cur   = st_q[snoop_line];
  assign same_line = snoop_valid && (snoop_line == cpu_req_line);
  assign cpu_state = cpu_cur;
  assign bus_req_op = req_op_w;

  mesi_cpu_side u_cpu (
    .req_valid (cpu_req_valid),
    .req_op    (cpu_op_t'(cpu_req_op)),
    .cur_st    (cpu_cur),
    .grant     (bus_grant),
    .shared_in (bus_shared_in),
    .blocked   (same_line),
    .bus_req   (bus_req),
    .bus_op    (req_op_w),
    .done      (cpu_done),
    .nxt_st    (cpu_nxt)
  );

  mesi_snoop_side u_snp (
    .snp_valid  (snoop_valid),
    .snp_op     (bus_op_t'(snoop_op)),
    .cur_st     (snp_cur),
    .flush      (flush),
    .shared_out (shared_out),
    .upd        (snp_upd),
    .nxt_st     (snp_nxt)
  );

  mesi_state_store #(.LINES(LINES)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .snp_we  (snp_upd),
    .snp_idx (snoop_line),
    .snp_st  (snp_nxt),
    .cpu_we  (cpu_done),
    .cpu_idx (cpu_req_line),
    .cpu_st  (cpu_nxt),
    .st_q    (st_q)
  );

  // R10: the bus carries one transaction per cycle
  a_r10_one_bus_owner: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_grant && snoop_valid));

  a_r2_read_hit_local: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_op == 2'd0 && cpu_state != 2'd0) |-> !bus_req);

  a_r3_fill_state: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant && bus_req && bus_req_op == 2'd1) |=>
      (st_q[$past(cpu_req_line)] == ($past(bus_shared_in) ? ST_S : ST_E)));

  a_r4_excl_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_op == 2'd1 && cpu_state == 2'd2 && !snoop_valid) |=>
      (st_q[$past(cpu_req_line)] == ST_M));

  a_r5_rdx_gives_modified: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant && bus_req && bus_req_op == 2'd2) |=> (st_q[$past(cpu_req_line)] == ST_M));

  a_r7_flush_then_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && snoop_op == 2'd2) |=> (st_q[$past(snoop_line)] == ST_I));

  a_r6_flush_needs_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (snoop_valid && shared_out && (snoop_op == 2'd1 || snoop_op == 2'd2)));

  a_r8_writeback_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant && bus_req && bus_req_op == 2'd3) |=> (st_q[$past(cpu_req_line)] == ST_I));

endmodule

// File: tb/tb_mesi_line_ctrl.sv
module tb_mesi_line_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 4;
  localparam int IDX_W = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic cpu_req_valid;
  logic [1:0] cpu_req_op;
  logic [IDX_W-1:0] cpu_req_line;
  logic [1:0] cpu_state;
  logic cpu_done, bus_req;
  logic [1:0] bus_req_op;
  logic bus_grant, bus_shared_in, snoop_valid;
  logic [1:0] snoop_op;
  logic [IDX_W-1:0] snoop_line;
  logic flush, shared_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [1:0] mdl [LINES];

  always #(CLK_PERIOD/2) clk = ~clk;

  mesi_line_ctrl #(.LINES(LINES)) dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_op(cpu_req_op), .cpu_req_line(cpu_req_line),
    .cpu_state(cpu_state), .cpu_done(cpu_done),
    .bus_req(bus_req), .bus_req_op(bus_req_op),
    .bus_grant(bus_grant), .bus_shared_in(bus_shared_in),
    .snoop_valid(snoop_valid), .snoop_op(snoop_op), .snoop_line(snoop_line),
    .flush(flush), .shared_out(shared_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // expected local behaviour: bus op needed and resulting state
  function automatic void exp_cpu(input logic [1:0] s, input logic [1:0] op, input bit sh,
                                  output logic [1:0] nb, output logic [1:0] ns);
    nb = 2'd0; ns = s;
    case (op)
      2'd0: if (s == 2'd0) begin nb = 2'd1; ns = sh ? 2'd1 : 2'd2; end
      2'd1: begin if (s == 2'd0 || s == 2'd1) nb = 2'd2; ns = 2'd3; end
      2'd2: begin if (s == 2'd3) nb = 2'd3; ns = 2'd0; end
      default: ;
    endcase
  endfunction

  function automatic void exp_snp(input logic [1:0] s, input logic [1:0] op,
                                  output logic fl, output logic [1:0] ns);
    fl = 1'b0; ns = s;
    if (op == 2'd1) begin fl = (s == 2'd3); if (s >= 2'd2) ns = 2'd1; end
    else if (op == 2'd2) begin fl = (s == 2'd3); ns = 2'd0; end
  endfunction

  task automatic apply_cpu(input logic [1:0] op, input int line, input bit sh);
    logic [1:0] nb, ns;
    string tag;
    exp_cpu(mdl[line], op, sh, nb, ns);
    case (op)
      2'd0: tag = (mdl[line] == 2'd0) ? "R3" : "R2";
      2'd1: tag = (nb != 0) ? "R5" : "R4";
      default: tag = "R8";
    endcase
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_op = op; cpu_req_line = IDX_W'(line);
    #1;
    chk(tag, int'(bus_req), int'(nb != 2'd0));
    chk(tag, int'(bus_req_op), int'(nb));
    if (nb != 2'd0) begin
      chk(tag, int'(cpu_done), 0);
      bus_grant = 1'b1; bus_shared_in = sh;
      #1;
    end
    chk(tag, int'(cpu_done), 1);
    @(posedge clk); #1;
    cpu_req_valid = 1'b0; bus_grant = 1'b0; bus_shared_in = 1'b0;
    mdl[line] = ns;
    @(negedge clk); #1;
    chk(tag, int'(cpu_state), int'(ns));
  endtask

  task automatic apply_snp(input logic [1:0] op, input int line);
    logic fl;
    logic [1:0] ns;
    string tag;
    exp_snp(mdl[line], op, fl, ns);
    tag = (op == 2'd1) ? "R6" : (op == 2'd2) ? "R7" : "R9";
    @(negedge clk);
    snoop_valid = 1'b1; snoop_op = op; snoop_line = IDX_W'(line);
    cpu_req_line = IDX_W'(line);
    #1;
    chk(tag, int'(flush), int'(fl));
    chk("R9", int'(shared_out), int'(mdl[line] != 2'd0));
    @(posedge clk); #1;
    snoop_valid = 1'b0; snoop_op = 2'd0;
    mdl[line] = ns;
    @(negedge clk); #1;
    chk(tag, int'(cpu_state), int'(ns));
  endtask

  task automatic goto_state(input int line, input logic [1:0] s);
    apply_cpu(2'd2, line, 1'b0);
    case (s)
      2'd1: apply_cpu(2'd0, line, 1'b1);
      2'd2: apply_cpu(2'd0, line, 1'b0);
      2'd3: apply_cpu(2'd1, line, 1'b0);
      default: ;
    endcase
  endtask

  task automatic read_state(input int line, input string tag);
    @(negedge clk); cpu_req_line = IDX_W'(line); #1;
    chk(tag, int'(cpu_state), int'(mdl[line]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cpu_req_valid = 0; cpu_req_op = 0; cpu_req_line = 0;
    bus_grant = 0; bus_shared_in = 0;
    snoop_valid = 0; snoop_op = 0; snoop_line = 0;
    for (int i = 0; i < LINES; i++) mdl[i] = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state of every line
    for (int i = 0; i < LINES; i++) read_state(i, "R1");

    // exhaustive sweep: each start state x each event, on two lines
    for (int ln = 0; ln < LINES; ln += 3) begin
      for (int s = 0; s < 4; s++) begin
        for (int ev = 0; ev < 7; ev++) begin
          goto_state(ln, 2'(s));
          case (ev)
            0: apply_cpu(2'd0, ln, 1'b0);
            1: apply_cpu(2'd0, ln, 1'b1);
            2: apply_cpu(2'd1, ln, 1'b0);
            3: apply_cpu(2'd2, ln, 1'b0);
            4: apply_snp(2'd1, ln);
            5: apply_snp(2'd2, ln);
            default: apply_snp(2'd3, ln);
          endcase
        end
      end
    end

    // R10: snoop on another line leaves this one alone
    goto_state(1, 2'd3);
    goto_state(2, 2'd2);
    apply_snp(2'd2, 2);
    read_state(1, "R10");

    // R10: same-line snoop stalls a local write to Exclusive
    goto_state(0, 2'd2);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_op = 2'd1; cpu_req_line = 2'd0;
    snoop_valid = 1'b1; snoop_op = 2'd1; snoop_line = 2'd0;
    #1;
    chk("R10", int'(cpu_done), 0);
    chk("R10", int'(bus_req), 0);
    @(posedge clk); #1;
    snoop_valid = 1'b0; snoop_op = 2'd0;
    mdl[0] = 2'd1;
    @(negedge clk); #1;
    chk("R10", int'(cpu_state), 1);
    chk("R10", int'(bus_req_op), 2);
    bus_grant = 1'b1; #1;
    chk("R10", int'(cpu_done), 1);
    @(posedge clk); #1;
    cpu_req_valid = 1'b0; bus_grant = 1'b0; mdl[0] = 2'd3;
    read_state(0, "R5");

    // R11: grant with nothing pending
    goto_state(3, 2'd1);
    @(negedge clk);
    cpu_req_valid = 1'b0; cpu_req_op = 2'd1; cpu_req_line = 2'd3;
    bus_grant = 1'b1; bus_shared_in = 1'b0;
    #1; chk("R11", int'(bus_req), 0);
    @(posedge clk); #1; bus_grant = 1'b0;
    read_state(3, "R11");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule